// File: doc/BRIEF.md
# Floating-Point Special-Value and Exception Stage

This stage sits after a single-precision add/subtract/divide datapath. Each operation it receives carries both operands, the operation code, and the datapath's finite result with its raw overflow flag and sign. The stage sorts each operand into one of four classes: finite, zero, infinity or NaN. From those classes it decides whether the final answer is the datapath result or a special value (infinity, signed zero or the quiet NaN). It also detects three exceptions: invalid operation, division by zero and overflow.

A status word holds three fields. The first is the exception cause of the latest operation. The second is a per-exception trap enable. The third is a sticky exception record. When an exception is detected and its enable is set, the stage raises a trap request and returns zero in place of a result. When the enable is clear, the stage returns the standard default value and records the exception in the sticky field. Software can rewrite the whole status word in one write.

Top module: `fpsv_handler`

## Requirements
- R1: After reset, `res_valid`, `trap_req`, `res_bits` and `status` are all zero. `res_valid` is high exactly one cycle after each cycle with `op_valid` high.
- R2: Operation codes are 0 add, 1 subtract, 2 or 3 divide. If either operand is a NaN (exponent all ones, mantissa non-zero), the result is the quiet NaN 0x7FC00000 and no exception is raised.
- R3: In add or subtract, with the sign of b inverted for subtract, two infinities of equal sign give that infinity. A single infinite operand gives that infinity. No exception is raised.
- R4: In add or subtract, infinities of opposite effective sign raise invalid (cause bit 0). The masked result is 0x7FC00000. Overflow is not flagged.
- R5: Dividing a finite non-zero value by a zero raises division by zero (cause bit 1). The masked result is infinity whose sign is the XOR of the operand signs; for example, 1.0 / -0.0 gives 0xFF800000.
- R6: Dividing zero by zero or infinity by infinity raises invalid. The masked result is 0x7FC00000.
- R7: If no operand is special and `raw_ovf` is high, overflow (cause bit 2) is raised. The masked result is infinity with the sign `raw_sgn`.
- R8: If any raised cause bit has its enable bit set, `trap_req` is high for that result cycle and `res_bits` is zero. Enabled causes are not added to the sticky field.
- R9: Causes that are raised while their enable is clear are ORed into the sticky field. Sticky bits clear only through a status write.
- R10: Every operation overwrites the cause field, so an operation that raises no exception leaves the field at zero.
- R11: Operations with no special operand and no overflow return `raw_res` unchanged, with no exception.
- R12: `status` is {sticky[8:6], enable[5:3], cause[2:0]}, and `csr_wr` loads it from `csr_wdata`. If a write and an operation fall in the same cycle, the operation is judged against the enables held before the write. Its masked causes are ORed onto the written sticky value, and its cause replaces the written cause.
- R13: In divide, infinity over a finite value gives infinity. A finite value over infinity gives zero. Zero over a finite non-zero value gives zero. In each case the sign is the XOR of the operand signs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 2 | 0 add, 1 subtract, 2/3 divide |
| a_bits | input | 32 | Operand a, single precision |
| b_bits | input | 32 | Operand b, single precision |
| raw_ovf | input | 1 | Datapath overflow indication |
| raw_sgn | input | 1 | Sign of the datapath result |
| raw_res | input | 32 | Datapath finite result |
| csr_wr | input | 1 | Status word write strobe |
| csr_wdata | input | 9 | Status word write value |
| res_valid | output | 1 | Result present |
| res_bits | output | 32 | Final result |
| trap_req | output | 1 | Trap request for this result |
| status | output | 9 | {sticky, enable, cause} |

## Verification
A status write and an operation can land in the same cycle, so the stage has to merge the written sticky and enable fields with the operation's own trap decision and sticky update. The bench does this deliberately. In one case the enables being written differ from the enables currently held, which shows which set decides the trap. In another case a write that clears the sticky field coincides with a masked exception, which shows whether the new sticky bit survives. A behavioural model applies the merge rule of R12 and is compared with the ports on every clock.

// File: rtl/fpsv_pkg.sv
package fpsv_pkg;
  typedef enum logic [1:0] {CL_FIN, CL_ZERO, CL_INF, CL_NAN} fclass_e;
  localparam int XW     = 3;
  localparam int EX_INV = 0;
  localparam int EX_DZ  = 1;
  localparam int EX_OVF = 2;
endpackage

// File: rtl/fpsv_classify.sv
module fpsv_classify
  import fpsv_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] x,
  output fclass_e              cls,
  output logic                 sgn
);
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] mn;
  assign ex  = x[MAN_W +: EXP_W];
  assign mn  = x[MAN_W-1:0];
  assign sgn = x[EXP_W+MAN_W];

  always_comb begin
    if (&ex)            cls = (|mn) ? CL_NAN : CL_INF;
    else if (ex == '0 && mn == '0) cls = CL_ZERO;
    else                cls = CL_FIN;
  end
endmodule

// File: rtl/fpsv_special.sv
module fpsv_special
  import fpsv_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic          op_div,
  input  logic          op_neg,
  input  fclass_e       a_cls,
  input  fclass_e       b_cls,
  input  logic          a_sgn,
  input  logic          b_sgn,
  input  logic          raw_ovf,
  input  logic          raw_sgn,
  input  logic [W-1:0]  raw_res,
  output logic [XW-1:0] cause,
  output logic [W-1:0]  dflt_res
);
  function automatic logic [W-1:0] inf_of(input logic s);
    return {s, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
  endfunction
  function automatic logic [W-1:0] zero_of(input logic s);
    return {s, {(W-1){1'b0}}};
  endfunction
  function automatic logic [W-1:0] qnan();
    return {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  endfunction

  logic eb_sgn, xs;
  assign eb_sgn = b_sgn ^ op_neg;
  assign xs     = a_sgn ^ b_sgn;

  always_comb begin
    cause    = '0;
    dflt_res = raw_res;
    if (a_cls == CL_NAN || b_cls == CL_NAN) begin
      dflt_res = qnan();
    end else if (!op_div) begin
      if (a_cls == CL_INF && b_cls == CL_INF) begin
        if (a_sgn != eb_sgn) begin
          cause[EX_INV] = 1'b1;
          dflt_res      = qnan();
        end else begin
          dflt_res = inf_of(a_sgn);
        end
      end else if (a_cls == CL_INF) begin
        dflt_res = inf_of(a_sgn);
      end else if (b_cls == CL_INF) begin
        dflt_res = inf_of(eb_sgn);
      end else if (raw_ovf) begin
        cause[EX_OVF] = 1'b1;
        dflt_res      = inf_of(raw_sgn);
      end
    end else begin
      if ((a_cls == CL_INF && b_cls == CL_INF) ||
          (a_cls == CL_ZERO && b_cls == CL_ZERO)) begin
        cause[EX_INV] = 1'b1;
        dflt_res      = qnan();
      end else if (a_cls == CL_INF) begin
        dflt_res = inf_of(xs);
      end else if (b_cls == CL_INF) begin
        dflt_res = zero_of(xs);
      end else if (b_cls == CL_ZERO) begin
        cause[EX_DZ] = 1'b1;
        dflt_res     = inf_of(xs);
      end else if (a_cls == CL_ZERO) begin
        dflt_res = zero_of(xs);
      end else if (raw_ovf) begin
        cause[EX_OVF] = 1'b1;
        dflt_res      = inf_of(raw_sgn);
      end
    end
  end
endmodule

// File: rtl/fpsv_status.sv
module fpsv_status
  import fpsv_pkg::*;
#(
  localparam int SW = 3 * XW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [XW-1:0] cause,
  input  logic          csr_wr,
  input  logic [SW-1:0] csr_wdata,
  output logic [XW-1:0] cause_q,
  output logic [XW-1:0] en_q,
  output logic [XW-1:0] sticky_q,
  output logic          trap_hit,
  output logic [XW-1:0] masked_new
);
  logic [XW-1:0] sticky_base;

  assign trap_hit    = op_valid & (|(cause & en_q));
  assign masked_new  = op_valid ? (cause & ~en_q) : '0;
  assign sticky_base = csr_wr ? csr_wdata[2*XW +: XW] : sticky_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_q  <= '0;
      en_q     <= '0;
      sticky_q <= '0;
    end else begin
      sticky_q <= sticky_base | masked_new;
      if (csr_wr) en_q <= csr_wdata[XW +: XW];
      if (op_valid)    cause_q <= cause;
      else if (csr_wr) cause_q <= csr_wdata[XW-1:0];
    end
  end
endmodule

// File: rtl/fpsv_handler.sv
module fpsv_handler
  import fpsv_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W  = 1 + EXP_W + MAN_W,
  localparam int SW = 3 * XW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [W-1:0]  a_bits,
  input  logic [W-1:0]  b_bits,
  input  logic          raw_ovf,
  input  logic          raw_sgn,
  input  logic [W-1:0]  raw_res,
  input  logic          csr_wr,
  input  logic [SW-1:0] csr_wdata,
  output logic          res_valid,
  output logic [W-1:0]  res_bits,
  output logic          trap_req,
  output logic [SW-1:0] status
);
  fclass_e       a_cls, b_cls;
  logic          a_sgn, b_sgn;
  logic [XW-1:0] cause, cause_q, en_q, sticky_q, masked_new;
  logic [W-1:0]  dflt_res;
  logic          trap_hit;

  fpsv_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
    .x(a_bits), .cls(a_cls), .sgn(a_sgn));
  fpsv_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
    .x(b_bits), .cls(b_cls), .sgn(b_sgn));

  fpsv_special #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_spec (
    .op_div(op_kind[1]), .op_neg(op_kind[0] & ~op_kind[1]),
    .a_cls(a_cls), .b_cls(b_cls), .a_sgn(a_sgn), .b_sgn(b_sgn),
    .raw_ovf(raw_ovf), .raw_sgn(raw_sgn), .raw_res(raw_res),
    .cause(cause), .dflt_res(dflt_res));

  fpsv_status u_stat (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .cause(cause),
    .csr_wr(csr_wr), .csr_wdata(csr_wdata), .cause_q(cause_q),
    .en_q(en_q), .sticky_q(sticky_q), .trap_hit(trap_hit),
    .masked_new(masked_new));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_bits  <= '0;
      trap_req  <= 1'b0;
    end else begin
      res_valid <= op_valid;
      trap_req  <= trap_hit;
      if (op_valid) res_bits <= trap_hit ? '0 : dflt_res;
    end
  end

  assign status = {sticky_q, en_q, cause_q};
endmodule

// File: rtl/fpsv_handler_chk.sv
module fpsv_handler_chk
  import fpsv_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic        csr_wr,
  input logic        res_valid,
  input logic [31:0] res_bits,
  input logic        trap_req,
  input logic [2:0]  cause_q,
  input logic [2:0]  sticky_q,
  input logic [2:0]  masked_new
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  a_r8_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (res_valid && res_bits == 32'h0));
  a_r9_sticky_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
  a_r9_sticky_source: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_wr |=> ((sticky_q & ~$past(sticky_q) & ~$past(masked_new)) == 3'b0));
  a_r10_single_cause: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0(cause_q));
  a_r4_invalid_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !trap_req && cause_q[EX_INV]) |-> res_bits == 32'h7FC00000);
  a_r5_dz_infinity: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !trap_req && cause_q[EX_DZ]) |->
      (res_bits[30:23] == 8'hFF && res_bits[22:0] == 23'h0));
endmodule

bind fpsv_handler fpsv_handler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .csr_wr(csr_wr),
  .res_valid(res_valid), .res_bits(res_bits), .trap_req(trap_req),
  .cause_q(cause_q), .sticky_q(sticky_q), .masked_new(masked_new));

// File: tb/fpsv_handler_test.sv
`timescale 1ns/1ps
module fpsv_handler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic [31:0] a_bits = 32'h0, b_bits = 32'h0, raw_res = 32'h0;
  logic        raw_ovf = 1'b0, raw_sgn = 1'b0, csr_wr = 1'b0;
  logic [8:0]  csr_wdata = 9'h0;
  logic        res_valid, trap_req;
  logic [31:0] res_bits;
  logic [8:0]  status;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string cur_tag = "R1";
  string m_tag = "R1";

  always #4 clk = ~clk;

  fpsv_handler uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .a_bits(a_bits), .b_bits(b_bits), .raw_ovf(raw_ovf), .raw_sgn(raw_sgn),
    .raw_res(raw_res), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .res_valid(res_valid), .res_bits(res_bits), .trap_req(trap_req),
    .status(status));

  // reference model state
  bit        m_valid, m_trap;
  bit [31:0] m_res;
  bit [2:0]  m_cause, m_en, m_sticky;

  localparam bit [31:0] QN = 32'h7FC00000;
  localparam bit [31:0] PINF = 32'h7F800000;

  function automatic bit f_nan(bit [31:0] v);  return v[30:23] == 8'd255 && v[22:0] != 0; endfunction
  function automatic bit f_inf(bit [31:0] v);  return v[30:0] == PINF[30:0]; endfunction
  function automatic bit f_zero(bit [31:0] v); return v[30:0] == 31'd0; endfunction

  task automatic ref_eval(input bit [1:0] k, input bit [31:0] a, input bit [31:0] b,
                          input bit ov, input bit rs, input bit [31:0] rr,
                          output bit [2:0] c, output bit [31:0] r);
    bit sa, sb, sx;
    sa = a[31];
    sb = (k == 2'd1) ? ~b[31] : b[31];
    sx = a[31] ^ b[31];
    c = 3'b000; r = rr;
    if (f_nan(a) || f_nan(b)) r = QN;
    else if (k < 2) begin
      if (f_inf(a) && f_inf(b) && sa != sb) begin c = 3'b001; r = QN; end
      else if (f_inf(a)) r = PINF | (32'(sa) << 31);
      else if (f_inf(b)) r = PINF | (32'(sb) << 31);
      else if (ov) begin c = 3'b100; r = PINF | (32'(rs) << 31); end
    end else begin
      if ((f_inf(a) && f_inf(b)) || (f_zero(a) && f_zero(b))) begin c = 3'b001; r = QN; end
      else if (f_inf(a)) r = PINF | (32'(sx) << 31);
      else if (f_inf(b)) r = 32'(sx) << 31;
      else if (f_zero(b)) begin c = 3'b010; r = PINF | (32'(sx) << 31); end
      else if (f_zero(a)) r = 32'(sx) << 31;
      else if (ov) begin c = 3'b100; r = PINF | (32'(rs) << 31); end
    end
  endtask

  always @(posedge clk) begin
    bit [2:0] c; bit [31:0] r; bit hit; bit [2:0] sb;
    if (!rst_n) begin
      m_valid = 0; m_trap = 0; m_res = 0; m_cause = 0; m_en = 0; m_sticky = 0;
      m_tag = "R1";
    end else begin
      m_tag = cur_tag;
      sb = csr_wr ? csr_wdata[8:6] : m_sticky;
      if (op_valid) begin
        ref_eval(op_kind, a_bits, b_bits, raw_ovf, raw_sgn, raw_res, c, r);
        hit = (c & m_en) != 0;
        m_valid = 1; m_trap = hit; m_res = hit ? 32'h0 : r;
        m_sticky = sb | (c & ~m_en);
        if (csr_wr) m_en = csr_wdata[5:3];
        m_cause = c;
      end else begin
        m_valid = 0; m_trap = 0;
        m_sticky = sb;
        if (csr_wr) begin m_en = csr_wdata[5:3]; m_cause = csr_wdata[2:0]; end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (res_valid !== m_valid || trap_req !== m_trap || res_bits !== m_res ||
          status !== {m_sticky, m_en, m_cause}) begin
        errors++;
        $display("FAIL %s: got v=%0b t=%0b res=%h st=%b expected v=%0b t=%0b res=%h st=%b",
                 m_tag, res_valid, trap_req, res_bits, status,
                 m_valid, m_trap, m_res, {m_sticky, m_en, m_cause});
      end
    end
  end

  task automatic step(input bit v, input bit [1:0] k, input bit [31:0] a, input bit [31:0] b,
                      input bit ov, input bit rs, input bit [31:0] rr,
                      input bit w, input bit [8:0] wd, input string tag);
    op_valid = v; op_kind = k; a_bits = a; b_bits = b;
    raw_ovf = ov; raw_sgn = rs; raw_res = rr; csr_wr = w; csr_wdata = wd;
    cur_tag = tag;
    @(negedge clk);
  endtask

  task automatic op(input bit [1:0] k, input bit [31:0] a, input bit [31:0] b,
                    input bit ov, input bit rs, input bit [31:0] rr, input string tag);
    step(1, k, a, b, ov, rs, rr, 0, 9'h0, tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 9'h0, tag);
  endtask

  task automatic wr(input bit [8:0] wd, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 1, wd, tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 9'h0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0, 0, 9'h0, "R1");
    op(0, 32'h3F800000, 32'h40000000, 0, 0, 32'h40400000, "R11");
    op(2, 32'h40C00000, 32'h40000000, 0, 0, 32'h40400000, "R11");
    op(0, 32'h7FC12345, 32'h3F800000, 0, 0, 32'h1, "R2");
    op(2, 32'h3F800000, 32'hFF800001, 0, 0, 32'h1, "R2");
    op(0, 32'h7F800000, 32'h7F800000, 0, 0, 32'h0, "R3");
    op(0, 32'hFF800000, 32'h3F800000, 1, 0, 32'h0, "R3");
    op(1, 32'h3F800000, 32'hFF800000, 0, 0, 32'h0, "R3");
    op(0, 32'h7F800000, 32'hFF800000, 0, 0, 32'h0, "R4");
    op(1, 32'hFF800000, 32'hFF800000, 0, 0, 32'h0, "R4");
    op(0, 32'h3F800000, 32'h3F800000, 0, 0, 32'h40000000, "R10");
    op(2, 32'h3F800000, 32'h80000000, 0, 0, 32'h0, "R5");
    op(2, 32'hC0000000, 32'h00000000, 0, 0, 32'h0, "R5");
    op(2, 32'h00000000, 32'h80000000, 0, 0, 32'h0, "R6");
    op(3, 32'h7F800000, 32'hFF800000, 0, 0, 32'h0, "R6");
    op(2, 32'hFF800000, 32'h40000000, 0, 0, 32'h0, "R13");
    op(2, 32'h40000000, 32'hFF800000, 0, 0, 32'h0, "R13");
    op(2, 32'h80000000, 32'h40400000, 0, 0, 32'h0, "R13");
    op(0, 32'h7F000000, 32'h7F000000, 1, 1, 32'h0, "R7");
    op(2, 32'h7F000000, 32'h00800000, 1, 0, 32'h0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 0, 9'h0, "R9");
    wr(9'b000_000_000, "R9");
    op(0, 32'h7F800000, 32'hFF800000, 0, 0, 32'h0, "R9");
    wr(9'b000_111_000, "R8");
    op(0, 32'h7F000000, 32'h7F000000, 1, 0, 32'h0, "R8");
    op(2, 32'h3F800000, 32'h00000000, 0, 0, 32'h0, "R8");
    // same-cycle write and operation: old enables (all set) decide the trap
    step(1, 0, 32'h7F000000, 32'h7F000000, 1, 0, 32'h0, 1, 9'b000_000_000, "R12");
    step(0, 0, 0, 0, 0, 0, 0, 0, 9'h0, "R12");
    // enables now clear: write clearing sticky races a masked invalid
    step(1, 0, 32'h7F800000, 32'hFF800000, 0, 0, 32'h0, 1, 9'b000_100_000, "R12");
    step(0, 0, 0, 0, 0, 0, 0, 0, 9'h0, "R12");
    wr(9'b110_000_010, "R12");
    op(0, 32'h3F800000, 32'h3F800000, 0, 0, 32'h40000000, "R10");
    repeat (2) step(0, 0, 0, 0, 0, 0, 0, 0, 9'h0, "R1");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule